// File: doc/BRIEF.md
# Bus Read Error Logger

This block watches an internal processor-bus interface for failed reads and keeps a record of the first one. A one-cycle error pulse, together with the address of the failing access, sets an error-valid flag, stores that address, and raises a read-error interrupt status bit. Later pulses are ignored until software clears the error-valid flag, so the logged address always belongs to the oldest unhandled failure.

A programmable configuration-window base marks the region of the address map that is used for configuration-space accesses. When a logged address has the same top byte as that base, a second flag records that the failure was a configuration-space access. Software clears each flag by writing a 1 to its bit, which matches the usual handler sequence of reading a status register and writing the value back. A level interrupt output is driven while the read-error status bit and its enable bit are both 1.

Software reaches everything through a single-cycle register port. Registers are 32 bits wide and are selected by a word index. Reads are combinational and have no side effects.

Top module: `buserr_logger`

## Requirements
- R1: A pulse on `err_valid_i` while the error-valid flag (index 0, bit 0) is clear sets that flag on the next clock edge.
- R2: On that same edge, the full 32-bit `err_addr_i` is latched and is readable at index 1.
- R3: Writing index 0 with bit 0 set clears the error-valid flag. Writing it with bit 0 clear has no effect. A capture in the same cycle takes priority over the clear.
- R4: While the error-valid flag is set, further error pulses change neither the logged address, nor the read-error status bit, nor the configuration-error flag.
- R5: A capture sets the read-error status bit (index 2, bit 0). Writing a 1 to that bit clears it, and a capture in the same cycle wins.
- R6: `irq_o` is 1 exactly when the read-error status bit and the interrupt enable bit (index 3, bit 0) are both 1.
- R7: The interrupt enable bit at index 3, bit 0 is read/write.
- R8: The configuration-window base is bits [31:24] of index 4. Those bits are read/write and the rest read as 0. A capture whose address bits [31:24] equal the base sets the configuration-error flag (index 5, bit 0). The base value in effect before the edge is the one compared.
- R9: Writing index 5 with bit 0 set clears the configuration-error flag, unless a matching capture happens in the same cycle.
- R10: Reads change no state. Indices 6 and 7 read as 0.
- R11: After reset, every register reads 0 and `irq_o` is 0.
- R12: Writes to index 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_valid_i | input | 1 | One-cycle failed-read strobe |
| err_addr_i | input | 32 | Address of the failed access |
| reg_addr_i | input | 3 | Register word index |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Level read-error interrupt |

## Verification
The bench focuses on cases where events collide. It sends an error pulse in the same cycle as a clear of the same flag. A design that lets the clear win would lose an error. It sends pulses while a capture is still held. A design that overwrites the held record would report the wrong address. It rewrites the window base in the same cycle as a capture, which catches a compare made against the new base. It also writes with bit 0 clear, which exposes a design that treats any write as a clear. Every cycle, the current register and `irq_o` are compared against a bench model, so a wrong priority or a bad window compare shows up as a miscompare on the exact register involved.

// File: rtl/buserr_pkg.sv
package buserr_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned RIDX_W  = 3;
  localparam int unsigned WIN_W   = 8;

  localparam logic [RIDX_W-1:0] IDX_ERR_CTL  = 3'd0;
  localparam logic [RIDX_W-1:0] IDX_ERR_ADDR = 3'd1;
  localparam logic [RIDX_W-1:0] IDX_INT_STAT = 3'd2;
  localparam logic [RIDX_W-1:0] IDX_INT_EN   = 3'd3;
  localparam logic [RIDX_W-1:0] IDX_WIN_BASE = 3'd4;
  localparam logic [RIDX_W-1:0] IDX_CFG_ERR  = 3'd5;
endpackage

// File: rtl/buserr_log.sv
module buserr_log #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pulse_i,
  input  logic [AW-1:0] addr_i,
  input  logic          clr_i,
  output logic          cap_o,
  output logic          valid_o,
  output logic [AW-1:0] addr_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;

  assign cap_o   = pulse_i & ~valid_q;
  assign valid_o = valid_q;
  assign addr_o  = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (cap_o)      valid_q <= 1'b1;
      else if (clr_i) valid_q <= 1'b0;
      if (cap_o)      addr_q  <= addr_i;
    end
  end

  // R1
  capture_sets_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> valid_q);
  // R2
  capture_latches_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> addr_q == $past(addr_i));
  // R4
  held_addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> $stable(addr_q));
  // R3
  clear_drops_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && clr_i) |=> !valid_q);
endmodule

// File: rtl/buserr_irq.sv
module buserr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic clr_i,
  input  logic en_we_i,
  input  logic en_d_i,
  output logic stat_o,
  output logic en_o,
  output logic irq_o
);
  logic stat_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (cap_i)      stat_q <= 1'b1;
      else if (clr_i) stat_q <= 1'b0;
      if (en_we_i)    en_q   <= en_d_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = stat_q & en_q;

  // R5
  stat_only_on_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q) |-> $past(cap_i));
  // R5
  capture_wins_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> stat_q);
endmodule

// File: rtl/buserr_cfgwin.sv
module buserr_cfgwin #(
  parameter int unsigned AW = 32,
  parameter int unsigned WW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [AW-1:0] addr_i,
  input  logic          base_we_i,
  input  logic [WW-1:0] base_d_i,
  input  logic          clr_i,
  output logic [WW-1:0] base_o,
  output logic          flag_o
);
  logic [WW-1:0] base_q;
  logic          flag_q;
  logic          hit;

  assign hit = cap_i && (addr_i[AW-1 -: WW] == base_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (base_we_i)  base_q <= base_d_i;
      if (hit)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign base_o = base_q;
  assign flag_o = flag_q;

  // R8
  flag_needs_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(cap_i));
  // R9
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !cap_i) |=> !flag_q);
endmodule

// File: rtl/buserr_logger.sv
module buserr_logger
  import buserr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_valid_i,
  input  logic [DATA_W-1:0] err_addr_i,
  input  logic [RIDX_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - WIN_W;

  logic              cap, valid, stat, en, cfg_flag;
  logic [DATA_W-1:0] log_addr;
  logic [WIN_W-1:0]  base;
  logic              w1c_bit;

  assign w1c_bit = reg_we_i & reg_wdata_i[0];

  buserr_log #(.AW(DATA_W)) u_log (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (err_valid_i),
    .addr_i  (err_addr_i),
    .clr_i   (w1c_bit && reg_addr_i == IDX_ERR_CTL),
    .cap_o   (cap),
    .valid_o (valid),
    .addr_o  (log_addr)
  );

  buserr_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .clr_i   (w1c_bit && reg_addr_i == IDX_INT_STAT),
    .en_we_i (reg_we_i && reg_addr_i == IDX_INT_EN),
    .en_d_i  (reg_wdata_i[0]),
    .stat_o  (stat),
    .en_o    (en),
    .irq_o   (irq_o)
  );

  buserr_cfgwin #(.AW(DATA_W), .WW(WIN_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .addr_i    (err_addr_i),
    .base_we_i (reg_we_i && reg_addr_i == IDX_WIN_BASE),
    .base_d_i  (reg_wdata_i[DATA_W-1 -: WIN_W]),
    .clr_i     (w1c_bit && reg_addr_i == IDX_CFG_ERR),
    .base_o    (base),
    .flag_o    (cfg_flag)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      IDX_ERR_CTL:  reg_rdata_o[0] = valid;
      IDX_ERR_ADDR: reg_rdata_o    = log_addr;
      IDX_INT_STAT: reg_rdata_o[0] = stat;
      IDX_INT_EN:   reg_rdata_o[0] = en;
      IDX_WIN_BASE: reg_rdata_o    = {base, {PAD_W{1'b0}}};
      IDX_CFG_ERR:  reg_rdata_o[0] = cfg_flag;
      default:      reg_rdata_o    = '0;
    endcase
  end

  // R6
  irq_tracks_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat && en));
  // R11
  always_comb if (!rst_ni) reset_quiet_chk: assert (!irq_o);
endmodule

// File: tb/buserr_logger_tb.sv
module buserr_logger_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        err_valid_i = 1'b0;
  logic [31:0] err_addr_i = '0;
  logic [2:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;

  // bench model
  logic        m_valid = 0, m_stat = 0, m_en = 0, m_cfg = 0;
  logic [31:0] m_addr = '0;
  logic [7:0]  m_base = '0;

  always #2 clk_i = ~clk_i;

  buserr_logger u_dut (.*);

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_valid};
      3'd1: return m_addr;
      3'd2: return {31'd0, m_stat};
      3'd3: return {31'd0, m_en};
      3'd4: return {m_base, 24'd0};
      3'd5: return {31'd0, m_cfg};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] a);
    case (a)
      3'd0: return "R1/R3";
      3'd1: return "R2/R4/R12";
      3'd2: return "R5";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R8/R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", r, act, exp);
    end
  endtask

  // Model update for the inputs currently applied, called at the clock edge.
  task automatic model_step();
    logic cap, w1;
    cap = err_valid_i && !m_valid;
    w1  = reg_we_i && reg_wdata_i[0];
    if (cap && err_addr_i[31:24] == m_base) m_cfg = 1;
    else if (w1 && reg_addr_i == 3'd5) m_cfg = 0;
    if (cap) begin m_valid = 1; m_addr = err_addr_i; m_stat = 1; end
    else begin
      if (w1 && reg_addr_i == 3'd0) m_valid = 0;
      if (w1 && reg_addr_i == 3'd2) m_stat = 0;
    end
    if (reg_we_i && reg_addr_i == 3'd3) m_en = reg_wdata_i[0];
    if (reg_we_i && reg_addr_i == 3'd4) m_base = reg_wdata_i[31:24];
  endtask

  // Apply one cycle: drive at negedge, compare combinational read, step model at posedge.
  task automatic cyc(input logic p, input logic [31:0] ea, input logic [2:0] a,
                     input logic we, input logic [31:0] wd);
    @(negedge clk_i);
    err_valid_i = p; err_addr_i = ea; reg_addr_i = a; reg_we_i = we; reg_wdata_i = wd;
    #1;
    check(tag(a), reg_rdata_o, exp_read(a));
    check("R6", {31'd0, irq_o}, {31'd0, m_stat & m_en});
    @(posedge clk_i);
    model_step();
  endtask

  task automatic rd(input logic [2:0] a);
    cyc(1'b0, 32'd0, a, 1'b0, 32'd0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    // R11: reset values of every index
    for (int i = 0; i < 8; i++) rd(3'(i));

    // R1 R2 R8: capture matching the window (base 0x00)
    cyc(1, 32'h00AB_CDEF, 3'd0, 0, 0);
    rd(3'd0); rd(3'd1); rd(3'd5); rd(3'd2);
    // R4: second pulse while held
    cyc(1, 32'h1234_5678, 3'd1, 0, 0);
    rd(3'd1);
    // R10: repeated reads are side-effect free
    rd(3'd0); rd(3'd0); rd(3'd2);
    // R12: write to address register ignored
    cyc(0, 0, 3'd1, 1, 32'hFFFF_FFFF);
    rd(3'd1);
    // R3: write with bit0 clear has no effect, then clear
    cyc(0, 0, 3'd0, 1, 32'hFFFF_FFFE);
    rd(3'd0);
    cyc(0, 0, 3'd0, 1, 32'h1);
    rd(3'd0);
    // R7 R6: enable irq
    cyc(0, 0, 3'd3, 1, 32'h1);
    rd(3'd3);
    // R5: capture and clear collide -> capture wins
    cyc(1, 32'h5500_0000, 3'd2, 1, 32'h1);
    rd(3'd2); rd(3'd1);
    // R9: clear cfg flag by write-back; R8 base change same cycle as capture
    cyc(0, 0, 3'd5, 1, 32'h1);
    rd(3'd5);
    cyc(0, 0, 3'd0, 1, 32'h1);
    cyc(1, 32'h7700_0010, 3'd4, 1, 32'h7700_0000);
    rd(3'd5); rd(3'd4);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] ea;
      logic [2:0]  a;
      ea = $urandom;
      if ($urandom_range(0, 1) == 0) ea[31:24] = m_base;
      a = 3'($urandom_range(0, 7));
      cyc($urandom_range(0, 3) == 0, ea, a, $urandom_range(0, 9) < 3,
          ($urandom_range(0, 3) == 0) ? {m_base ^ 8'h01, 24'h1} : 32'($urandom));
    end
    for (int i = 0; i < 8; i++) rd(3'(i));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule